// File: doc/BRIEF.md
# Log-Depth Parallel Prefix Adder

This block adds two unsigned W-bit operands and a single carry-in. It returns the W-bit sum and the carry-out. There is no clock and no state: the result settles combinationally, in the same cycle as the inputs. The block is meant to sit on an arithmetic datapath where the carry chain would otherwise set the cycle time.

Every bit position first forms a generate term (both operand bits set) and a propagate term (either operand bit set). A prefix tree of log2(W) levels then merges these pairs. In level s, each position merges its running pair with the pair held 2^s positions below it. Positions that have no partner that far down keep their pair unchanged. After the last level, every position holds the group generate and group propagate for the span from itself down to bit 0.

The carry-in enters the tree at the output, through the group propagate. The half-sum of each bit, XORed with its incoming carry, gives the sum bit. W must be a power of two and at least 2.

Top module: `lp_prefix_adder`

## Requirements
- R1: `sum_o` equals the low W bits of `a_i + b_i + ci_i`, taken as unsigned integers, for every input combination.
- R2: `co_o` equals bit W (the bit just above the sum) of `a_i + b_i + ci_i`.
- R3: With `a_i` all ones, `b_i` zero and `ci_i` = 1, the carry travels the full width: `sum_o` is zero and `co_o` is 1.
- R4: With only the top bit set in both operands, `co_o` is 1 and `sum_o` equals `ci_i` in bit 0 with every other bit zero.
- R5: With both operands zero, `co_o` is 0 and `sum_o` equals `ci_i` in bit 0 with every other bit zero.
- R6: For any fixed operands, the W+1-bit value {`co_o`,`sum_o`} with `ci_i` = 1 is exactly one more than the same value with `ci_i` = 0.
- R7: The outputs depend only on the present inputs. They are valid within the cycle in which the inputs change, with no register latency.
- R8: With both operands all ones, `co_o` is 1 and `sum_o` is all ones shifted left one place, with `ci_i` in bit 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | W | First unsigned operand |
| b_i | input | W | Second unsigned operand |
| ci_i | input | 1 | Carry into bit 0 |
| sum_o | output | W | Low W bits of the total |
| co_o | output | 1 | Carry out of the top bit |

## Verification
The bench sweeps every operand pair and carry-in of an 8-bit build, then drives random and directed vectors through a 32-bit build. Expected values come from integer addition. The directed cases aim at the longest carry path (all ones plus a carry-in) and at the top-position generate. A tree whose merge distances or pass-through positions were wrong would leave upper sum bits stale exactly when a carry must cross many positions. The carry-in step test catches a carry-in that is dropped or added at the wrong weight, which would shift the whole result by one or leave it unchanged. The zero and double-all-ones cases catch a carry-out built from the wrong group term: such a design would raise a spurious carry on zeros or miss the carry when every position generates.

// File: rtl/pfx_pkg.sv
package pfx_pkg;

  // group generate / propagate pair
  typedef struct packed {
    logic g;
    logic p;
  } gp_t;

  // merge a more significant group (hi) with the adjacent lower group (lo)
  function automatic gp_t gp_merge(input gp_t hi, input gp_t lo);
    gp_t r;
    r.g = hi.g | (hi.p & lo.g);
    r.p = hi.p & lo.p;
    return r;
  endfunction

endpackage

// File: rtl/pfx_bitcell.sv
module pfx_bitcell
  import pfx_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0]  a_i,
  input  logic [W-1:0]  b_i,
  output gp_t  [W-1:0]  gp_o,
  output logic [W-1:0]  hsum_o
);

  for (genvar i = 0; i < W; i++) begin : g_bit
    assign gp_o[i].g = a_i[i] & b_i[i];
    assign gp_o[i].p = a_i[i] | b_i[i];
  end

  assign hsum_o = a_i ^ b_i;

endmodule

// File: rtl/pfx_stage.sv
module pfx_stage
  import pfx_pkg::*;
#(
  parameter int W    = 32,
  parameter int DIST = 1
) (
  input  gp_t [W-1:0] gp_i,
  output gp_t [W-1:0] gp_o
);

  for (genvar i = 0; i < W; i++) begin : g_pos
    if (i >= DIST) begin : g_merge
      assign gp_o[i] = gp_merge(gp_i[i], gp_i[i-DIST]);
    end else begin : g_pass
      assign gp_o[i] = gp_i[i];
    end
  end

  // the lowest position never has a partner and must keep its pair
  always_comb begin
    AST_STAGE_LOW_PASS: assert (gp_o[0] == gp_i[0]); // R1
  end

endmodule

// File: rtl/pfx_tree.sv
module pfx_tree
  import pfx_pkg::*;
#(
  parameter int W = 32
) (
  input  gp_t [W-1:0] gp_i,
  output gp_t [W-1:0] grp_o
);

  localparam int LVLS = $clog2(W);

  gp_t [W-1:0] lvl [LVLS+1];

  assign lvl[0] = gp_i;

  for (genvar s = 0; s < LVLS; s++) begin : g_lvl
    pfx_stage #(
      .W    (W),
      .DIST (1 << s)
    ) u_stage (
      .gp_i (lvl[s]),
      .gp_o (lvl[s+1])
    );
  end

  assign grp_o = lvl[LVLS];

  // the top group propagate must cover every bit position
  logic all_prop;
  always_comb begin
    all_prop = 1'b1;
    for (int i = 0; i < W; i++) all_prop = all_prop & gp_i[i].p;
    AST_TOP_GROUP_PROP: assert (grp_o[W-1].p == all_prop); // R3
  end

endmodule

// File: rtl/pfx_sumcell.sv
module pfx_sumcell
  import pfx_pkg::*;
#(
  parameter int W = 32
) (
  input  gp_t  [W-1:0] grp_i,
  input  logic [W-1:0] hsum_i,
  input  logic         ci_i,
  output logic [W-1:0] sum_o,
  output logic         co_o
);

  logic [W:0] cy;

  assign cy[0] = ci_i;
  for (genvar i = 0; i < W; i++) begin : g_cy
    assign cy[i+1] = grp_i[i].g | (grp_i[i].p & ci_i);
  end

  assign sum_o = hsum_i ^ cy[W-1:0];
  assign co_o  = cy[W];

endmodule

// File: rtl/lp_prefix_adder.sv
module lp_prefix_adder
  import pfx_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         ci_i,
  output logic [W-1:0] sum_o,
  output logic         co_o
);

  gp_t  [W-1:0] bit_gp;
  gp_t  [W-1:0] grp_gp;
  logic [W-1:0] hsum;

  pfx_bitcell #(.W(W)) u_bit (
    .a_i    (a_i),
    .b_i    (b_i),
    .gp_o   (bit_gp),
    .hsum_o (hsum)
  );

  pfx_tree #(.W(W)) u_tree (
    .gp_i  (bit_gp),
    .grp_o (grp_gp)
  );

  pfx_sumcell #(.W(W)) u_sum (
    .grp_i  (grp_gp),
    .hsum_i (hsum),
    .ci_i   (ci_i),
    .sum_o  (sum_o),
    .co_o   (co_o)
  );

  logic [W:0] ref_total;
  always_comb begin
    ref_total = {1'b0, a_i} + {1'b0, b_i} + (W+1)'(ci_i);
    AST_SUM_LOW_BITS: assert (sum_o == ref_total[W-1:0]); // R1
    AST_CARRY_OUT: assert (co_o == ref_total[W]); // R2
    AST_ZERO_NO_CARRY: assert (!((a_i == '0) && (b_i == '0)) || !co_o); // R5
    AST_DOUBLE_ONES_CARRY: assert (!((a_i == '1) && (b_i == '1)) || co_o); // R8
  end

endmodule

// File: tb/test_lp_prefix_adder.sv
module test_lp_prefix_adder;

  localparam int NW = 8;
  localparam int WW = 32;

  logic clk = 1'b0;
  always #10 clk = ~clk; // 50 MHz

  logic [NW-1:0] a8, b8, s8;
  logic          c8, co8;
  logic [WW-1:0] aw, bw, sw;
  logic          cw, cow;

  int n_cmp = 0;
  int n_bad = 0;
  int cyc   = 0;

  lp_prefix_adder #(.W(NW)) i_lp_prefix_adder (
    .a_i (a8), .b_i (b8), .ci_i (c8), .sum_o (s8), .co_o (co8)
  );

  lp_prefix_adder #(.W(WW)) i_lp_prefix_adder_wide (
    .a_i (aw), .b_i (bw), .ci_i (cw), .sum_o (sw), .co_o (cow)
  );

  task automatic cmp(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // drive at the falling edge, sample 1 ns later in the same cycle (R7)
  task automatic run_n(input logic [NW-1:0] x, input logic [NW-1:0] y, input logic c,
                       input string ts, input string tc);
    logic [NW:0] e;
    @(negedge clk);
    a8 = x; b8 = y; c8 = c;
    #1;
    e = {1'b0, x} + {1'b0, y} + (NW+1)'(c);
    cmp(ts, 64'(s8), 64'(e[NW-1:0]));
    cmp(tc, 64'(co8), 64'(e[NW]));
  endtask

  task automatic run_w(input logic [WW-1:0] x, input logic [WW-1:0] y, input logic c,
                       input string ts, input string tc);
    logic [WW:0] e;
    @(negedge clk);
    aw = x; bw = y; cw = c;
    #1;
    e = {1'b0, x} + {1'b0, y} + (WW+1)'(c);
    cmp(ts, 64'(sw), 64'(e[WW-1:0]));
    cmp(tc, 64'(cow), 64'(e[WW]));
  endtask

  task automatic step_w(input logic [WW-1:0] x, input logic [WW-1:0] y);
    logic [WW:0] r0, r1;
    @(negedge clk);
    aw = x; bw = y; cw = 1'b0;
    #1 r0 = {cow, sw};
    cw = 1'b1;
    #1 r1 = {cow, sw};
    cmp("R6 carry-in step", 64'(r1), 64'(r0 + 1'b1));
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000) begin
      n_bad++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      finish_run();
    end
  end

  initial begin
    a8 = '0; b8 = '0; c8 = 1'b0;
    aw = '0; bw = '0; cw = 1'b0;

    // R5 zero operands, both carry-in values
    run_n('0, '0, 1'b0, "R5 zero sum", "R5 zero carry");
    run_n('0, '0, 1'b1, "R5 zero sum ci", "R5 zero carry ci");
    run_w('0, '0, 1'b1, "R5 wide zero sum", "R5 wide zero carry");
    // R3 full-width propagate
    run_n('1, '0, 1'b1, "R3 ripple sum", "R3 ripple carry");
    run_w('1, '0, 1'b1, "R3 wide ripple sum", "R3 wide ripple carry");
    run_w('0, '1, 1'b1, "R3 wide ripple sum b", "R3 wide ripple carry b");
    // R4 top-position generate
    run_n(8'h80, 8'h80, 1'b1, "R4 top gen sum", "R4 top gen carry");
    run_w(32'h8000_0000, 32'h8000_0000, 1'b0, "R4 wide top gen sum", "R4 wide top gen carry");
    // R8 every position generates
    run_n('1, '1, 1'b0, "R8 ones sum", "R8 ones carry");
    run_w('1, '1, 1'b1, "R8 wide ones sum", "R8 wide ones carry");
    // R6 carry-in weight
    step_w('1, '0);
    step_w(32'h5555_5555, 32'hAAAA_AAAA);
    step_w(32'h0000_FFFF, 32'h0000_0001);

    // R1 / R2 exhaustive sweep of the narrow build
    for (int x = 0; x < (1 << NW); x++)
      for (int y = 0; y < (1 << NW); y++)
        for (int c = 0; c < 2; c++)
          run_n(NW'(x), NW'(y), c[0], "R1 sweep sum", "R2 sweep carry");

    // R1 / R2 random vectors on the wide build
    for (int k = 0; k < 2000; k++)
      run_w($urandom, $urandom, 1'($urandom), "R1 random sum", "R2 random carry");

    // R6 random carry-in steps
    for (int k = 0; k < 50; k++)
      step_w($urandom, $urandom);

    finish_run();
  end

endmodule